// File: doc/BRIEF.md
# Multi-core hardware semaphore with ordered wait queue

This block guards one shared resource among a set of processor cores. A core asks for the semaphore in one of two ways. A polling request gets an answer one cycle later: granted if the semaphore was free, busy if not. On busy, the core simply asks again later. A waiting request that cannot be granted at once is parked in a queue. The core is then interrupted when ownership passes to it.

Every decision is made in a single clock cycle from the registered state. A request, a grant and a queue insertion can therefore never interleave, and at most one core is ever the owner. When several cores ask in the same cycle, the lowest core index is handled first. Cores that are already waiting in the queue take precedence over cores that poll. Requests that break the protocol are discarded and reported on a per-core error pulse. Such a request is a request from the owner or from a core already waiting, or a release from a core that does not own the semaphore.

Top module: `hw_sem_queue`

## Requirements
- R1: At most one core owns the semaphore. When several cores request a free semaphore with an empty queue in the same cycle, the lowest-index requester becomes owner and the others are handled as if the semaphore were held.
- R2: A polling request (mode bit 0) from a core that neither owns nor waits gives a `done_o` pulse for that core in the next cycle. `gnt_o` is 1 in that pulse when the core became owner, and 0 (busy) otherwise.
- R3: A waiting request (mode bit 1) that cannot be granted places the core at the tail of the queue. It produces no `done_o` pulse and leaves the current owner unchanged.
- R4: When the owner releases and the queue is not empty, the core at the head of the queue becomes owner in the next cycle and its `irq_o` line is asserted.
- R5: Queued cores become owner strictly in arrival order. Waiting requests arriving in the same cycle enter the queue lowest core index first.
- R6: The queue holds NCORE-1 entries. With every core except the owner waiting, all of them are still served in order.
- R7: A polling request made while the queue is not empty answers busy, even when the owner releases in that same cycle.
- R8: When the owner releases with an empty queue and no request pending, the semaphore becomes free (`owner_o` all zero) in the next cycle.
- R9: A request from the owner or from a queued core, and a release from a core that is not the owner, change neither ownership nor the queue. Each one gives an `err_o` pulse for that core in the next cycle.
- R10: A waiting request granted at once, like a grant from the queue, sets that core's `irq_o`. The line stays high until the core raises `ack_i`, and the acknowledge does not change ownership.
- R11: After reset, `owner_o`, `irq_o`, `done_o`, `gnt_o` and `err_o` are all zero and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NCORE | Per-core request strobe, one cycle per request |
| mode_i | input | NCORE | Per-core request kind: 0 polling, 1 waiting (interrupt) |
| rel_i | input | NCORE | Per-core release strobe |
| ack_i | input | NCORE | Per-core interrupt acknowledge |
| owner_o | output | NCORE | One-hot current owner, zero when free |
| done_o | output | NCORE | Pulse answering a polling request |
| gnt_o | output | NCORE | Valid with done_o: 1 granted, 0 busy |
| irq_o | output | NCORE | Per-core ownership interrupt, held until acknowledged |
| err_o | output | NCORE | Pulse flagging a discarded request or release |

## Verification
The embedded properties assume only that each input holds a known level at every rising edge. Any mix of requests, modes, releases and acknowledges is legal input, including the protocol violations covered by R9. The bench drives all inputs just after the falling edge. Its random phase deliberately includes stray releases, duplicate requests and simultaneous requests, so the error paths and same-cycle ordering rules are exercised rather than avoided. Releases are biased toward the current owner so that queue hand-offs happen often.

// File: rtl/hw_sem_queue.sv
module hw_sem_queue #(
  parameter int NCORE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] req_i,
  input  logic [NCORE-1:0] mode_i,
  input  logic [NCORE-1:0] rel_i,
  input  logic [NCORE-1:0] ack_i,
  output logic [NCORE-1:0] owner_o,
  output logic [NCORE-1:0] done_o,
  output logic [NCORE-1:0] gnt_o,
  output logic [NCORE-1:0] irq_o,
  output logic [NCORE-1:0] err_o
);
  localparam int IDW = (NCORE > 1) ? $clog2(NCORE) : 1;
  localparam int QD  = (NCORE > 1) ? NCORE - 1 : 1;
  localparam int CW  = $clog2(QD + 1) + 1;

  logic             own_v, n_own_v;
  logic [IDW-1:0]   own, n_own;
  logic [IDW-1:0]   q   [QD];
  logic [IDW-1:0]   n_q [QD];
  logic [CW-1:0]    cnt, n_cnt;
  logic [NCORE-1:0] qm, n_irq, n_done, n_gnt, n_err;
  logic             rel_ok, avail;

  assign owner_o = own_v ? (NCORE'(1) << own) : '0;
  assign rel_ok  = own_v && rel_i[own];

  always_comb begin
    qm = '0;
    for (int i = 0; i < QD; i++)
      if (i < int'(cnt)) qm[q[i]] = 1'b1;
  end

  always_comb begin
    n_own_v = own_v;
    n_own   = own;
    n_q     = q;
    n_cnt   = cnt;
    n_irq   = irq_o & ~ack_i;
    n_done  = '0;
    n_gnt   = '0;
    n_err   = '0;

    for (int c = 0; c < NCORE; c++)
      if (rel_i[c] && !(own_v && own == IDW'(c))) n_err[c] = 1'b1;

    if (rel_ok) begin
      if (cnt != '0) begin
        n_own        = q[0];
        n_irq[q[0]]  = 1'b1;
        for (int i = 0; i < QD - 1; i++) n_q[i] = q[i+1];
        n_cnt        = cnt - 1'b1;
      end else begin
        n_own_v = 1'b0;
      end
    end

    avail = (!own_v || rel_ok) && (cnt == '0);

    for (int c = 0; c < NCORE; c++) begin
      if (req_i[c]) begin
        if ((own_v && own == IDW'(c)) || qm[c]) begin
          n_err[c] = 1'b1;
        end else if (avail) begin
          avail   = 1'b0;
          n_own_v = 1'b1;
          n_own   = IDW'(c);
          if (mode_i[c]) n_irq[c] = 1'b1;
          else begin
            n_done[c] = 1'b1;
            n_gnt[c]  = 1'b1;
          end
        end else if (mode_i[c]) begin
          for (int i = 0; i < QD; i++)
            if (i == int'(n_cnt)) n_q[i] = IDW'(c);
          n_cnt = n_cnt + 1'b1;
        end else begin
          n_done[c] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_v  <= 1'b0;
      own    <= '0;
      cnt    <= '0;
      irq_o  <= '0;
      done_o <= '0;
      gnt_o  <= '0;
      err_o  <= '0;
      for (int i = 0; i < QD; i++) q[i] <= '0;
    end else begin
      own_v  <= n_own_v;
      own    <= n_own;
      cnt    <= n_cnt;
      irq_o  <= n_irq;
      done_o <= n_done;
      gnt_o  <= n_gnt;
      err_o  <= n_err;
      q      <= n_q;
    end
  end

  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= QD);  // R6

  AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_ok && cnt != '0) |=> (own_v && own == $past(q[0]) && irq_o[own]));  // R4

  AST_FREE_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_ok && cnt == '0 && req_i == '0) |=> !own_v);  // R8

  for (genvar g = 0; g < NCORE; g++) begin : g_core_chk
    AST_DIRECT_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[g] && !mode_i[g] && !owner_o[g] && !qm[g]) |=> done_o[g]);  // R2

    AST_GNT_IS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_o[g] |-> owner_o[g]);  // R1

    AST_POLL_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[g] && !mode_i[g] && !owner_o[g] && !qm[g] && cnt != '0)
        |=> (done_o[g] && !gnt_o[g]));  // R7

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o[g] && !ack_i[g]) |=> irq_o[g]);  // R10

    AST_OWNER_REQ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[g] && owner_o[g] && !rel_i[g]) |=> (err_o[g] && owner_o[g]));  // R9
  end
endmodule

// File: tb/hw_sem_queue_bench.sv
`timescale 1ns/1ps
module hw_sem_queue_bench;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, mode = '0, rel = '0, ack = '0;
  logic [N-1:0] owner, done, gnt, irq, err;

  int checks = 0;
  int failures = 0;

  int mq [N];
  int mcnt;
  bit m_ov;
  int m_o;
  logic [N-1:0] m_irq, e_done, e_gnt, e_err;

  always #4 clk = ~clk;

  hw_sem_queue #(.NCORE(N)) u_hw_sem_queue (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode), .rel_i(rel),
    .ack_i(ack), .owner_o(owner), .done_o(done), .gnt_o(gnt),
    .irq_o(irq), .err_o(err)
  );

  function automatic logic [N-1:0] exp_owner();
    return m_ov ? (N'(1) << m_o) : '0;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input logic [N-1:0] rq, md, rl, ak);
    int nq [N];
    int ncnt, no;
    bit nov, relok, freeok;
    logic [N-1:0] qmk;
    nq = mq; ncnt = mcnt; nov = m_ov; no = m_o;
    e_done = '0; e_gnt = '0; e_err = '0;
    m_irq = m_irq & ~ak;
    qmk = '0;
    for (int i = 0; i < mcnt; i++) qmk[mq[i]] = 1'b1;
    relok = m_ov && rl[m_o];
    for (int c = 0; c < N; c++)
      if (rl[c] && !(m_ov && m_o == c)) e_err[c] = 1'b1;
    if (relok) begin
      if (mcnt > 0) begin
        no = mq[0];
        m_irq[no] = 1'b1;
        for (int i = 0; i < N - 1; i++) nq[i] = mq[i+1];
        ncnt = mcnt - 1;
      end else nov = 1'b0;
    end
    freeok = (!m_ov || relok) && mcnt == 0;
    for (int c = 0; c < N; c++) begin
      if (!rq[c]) continue;
      if ((m_ov && m_o == c) || qmk[c]) e_err[c] = 1'b1;
      else if (freeok) begin
        freeok = 1'b0; nov = 1'b1; no = c;
        if (md[c]) m_irq[c] = 1'b1;
        else begin e_done[c] = 1'b1; e_gnt[c] = 1'b1; end
      end else if (md[c]) begin
        nq[ncnt] = c; ncnt++;
      end else e_done[c] = 1'b1;
    end
    mq = nq; mcnt = ncnt; m_ov = nov; m_o = no;
  endtask

  task automatic cyc(input logic [N-1:0] rq, md, rl, ak);
    @(negedge clk);
    req = rq; mode = md; rel = rl; ack = ak;
    model_step(rq, md, rl, ak);
    @(posedge clk);
    #1;
    chk("R1 owner", owner, exp_owner());
    chk("R2 done", done, e_done);
    chk("R2 gnt", gnt, e_gnt);
    chk("R10 irq", irq, m_irq);
    chk("R9 err", err, e_err);
    @(negedge clk);
    req = '0; rel = '0; ack = '0; mode = '0;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    m_ov = 0; m_o = 0; mcnt = 0; m_irq = '0;
    for (int i = 0; i < N; i++) mq[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11 owner", owner, '0);
    chk("R11 irq", irq, '0);
    chk("R11 done", done, '0);
    chk("R11 err", err, '0);
    @(negedge clk);
    rst_n = 1'b1;

    cyc(4'b0001, 4'b0000, '0, '0);
    chk("R2 poll grant", gnt, 4'b0001);
    cyc(4'b0010, 4'b0000, '0, '0);
    chk("R2 poll busy", {done[1], gnt[1]}, 4'b0010);
    cyc(4'b1100, 4'b1100, '0, '0);
    chk("R3 queued no answer", done, '0);
    chk("R3 owner kept", owner, 4'b0001);
    cyc(4'b0010, 4'b0000, 4'b0001, '0);
    chk("R4 head owns", owner, 4'b0100);
    chk("R4 head irq", irq, 4'b0100);
    chk("R7 poll busy over queue", {done[1], gnt[1]}, 4'b0010);
    cyc(4'b0100, 4'b0100, '0, '0);
    chk("R9 owner request", err, 4'b0100);
    cyc(4'b1000, 4'b1000, 4'b0010, '0);
    chk("R9 queued request and stray release", err, 4'b1010);
    chk("R9 owner unchanged", owner, 4'b0100);
    cyc('0, '0, '0, 4'b0100);
    chk("R10 ack clears irq", irq, '0);
    chk("R10 ack keeps owner", owner, 4'b0100);
    cyc('0, '0, 4'b0100, '0);
    chk("R5 next in order", owner, 4'b1000);
    cyc('0, '0, 4'b1000, 4'b1000);
    chk("R8 free", owner, '0);
    cyc(4'b1111, 4'b0000, '0, '0);
    chk("R1 lowest wins", gnt, 4'b0001);
    chk("R1 all answered", done, 4'b1111);
    cyc(4'b1110, 4'b1110, '0, '0);
    cyc('0, '0, 4'b0001, '0);
    chk("R6 full queue head", owner, 4'b0010);
    cyc('0, '0, 4'b0010, '0);
    chk("R5 second", owner, 4'b0100);
    cyc('0, '0, 4'b0100, '0);
    chk("R6 last", owner, 4'b1000);
    cyc('0, '0, 4'b1000, 4'b1111);
    chk("R8 free again", owner, '0);
    cyc(4'b0100, 4'b0100, '0, '0);
    chk("R10 immediate irq", irq, 4'b0100);
    chk("R10 immediate no done", done, '0);
    cyc('0, '0, 4'b0100, 4'b0100);

    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] rq, md, rl, ak;
      rq = N'($urandom) & N'($urandom);
      md = N'($urandom);
      rl = (($urandom % 8) == 0) ? N'($urandom) : '0;
      if (m_ov && ($urandom % 3) == 0) rl[m_o] = 1'b1;
      ak = N'($urandom) & N'($urandom);
      cyc(rq, md, rl, ak);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
  end
endmodule